// File: doc/BRIEF.md
# Intra-Group Store-Load Overlap Detector

This block keeps a small table of the stores committed in the current dispatch group. A scheduler uses it to see whether a candidate load would read memory that one of those stores writes, and inserts a no-op when it would. Every access is described symbolically. It has a base identifier, a signed byte offset from that base, and a size in bytes. No effective address is ever formed.

Stores are recorded on a commit strobe when the committing instruction is a store and carries memory-operand information. The table has four slots by default. Stores beyond that count in one group are dropped. A group-end strobe empties the table. The overlap flag is combinational in the presented load. It is high only while a load with valid operand information is presented and at least one recorded store hits it.

Top module: `store_load_overlap`

## Requirements
- R1: At most NUM_SLOTS (default 4) stores are recorded per group. A store committed after the table is full is not recorded and never causes an overlap.
- R2: A load whose base and offset both equal those of a recorded store is flagged, whatever either size is, including size 0.
- R3: When the bases are equal and the store offset is strictly less than the load offset, the load is flagged exactly when store offset plus store size is greater than the load offset.
- R4: When the bases are equal and the store offset is greater than or equal to the load offset, the load is flagged exactly when load offset plus load size is greater than the store offset.
- R5: A recorded store with a different base identifier never flags a load.
- R6: overlap_o is low unless chk_is_load_i and chk_opnd_vld_i are both high.
- R7: A store is recorded at a rising clock edge only when commit_i, commit_is_store_i and commit_opnd_vld_i are all high at that edge.
- R8: group_end_i empties the table at the next edge. A commit in the same cycle as group_end_i is dropped. Recording restarts in the following cycle.
- R9: After reset the table is empty and no load is flagged.
- R10: Offsets are two's-complement signed, sizes are unsigned, and the sums are compared as signed values of the offset width.

Ports are listed in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| group_end_i | input | 1 | Dispatch group ends; clears the table |
| commit_i | input | 1 | An instruction commits this cycle |
| commit_is_store_i | input | 1 | The committing instruction writes memory |
| commit_opnd_vld_i | input | 1 | The memory-operand description of the commit is present |
| st_base_i | input | BASE_W (16) | Base identifier of the committing store |
| st_off_i | input | OFF_W (64) | Signed offset of the committing store |
| st_size_i | input | OFF_W (64) | Size in bytes of the committing store |
| chk_is_load_i | input | 1 | The candidate instruction reads memory |
| chk_opnd_vld_i | input | 1 | The memory-operand description of the candidate is present |
| ld_base_i | input | BASE_W (16) | Base identifier of the candidate load |
| ld_off_i | input | OFF_W (64) | Signed offset of the candidate load |
| ld_size_i | input | OFF_W (64) | Size in bytes of the candidate load |
| overlap_o | output | 1 | Candidate load overlaps a store recorded in this group |

## Verification
A slot that is stale or was never written shows up in the next combinational probe. A missed clear gives a spurious overlap_o on the first load probed after group_end_i. A dropped write gives a missing flag on the first probe of that store's footprint. A fill counter that does not saturate correctly either loses the fourth store or records the fifth. Probes placed exactly at the end of a footprint and one byte past it show both failures in the cycle after the commit. Off-by-one and signedness faults in the compare appear at once on probes that straddle each range boundary, including negative offsets.

// File: rtl/sld_pkg.sv
package sld_pkg;
  parameter int unsigned BASE_W = 16;
  parameter int unsigned OFF_W  = 64;

  typedef struct packed {
    logic [BASE_W-1:0]       base;
    logic signed [OFF_W-1:0] off;
    logic [OFF_W-1:0]        size;
  } mem_acc_t;
endpackage

// File: rtl/sld_fill_ctrl.sv
module sld_fill_ctrl #(
  parameter int unsigned NUM_SLOTS = 4,
  localparam int unsigned CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 push_i,
  output logic [NUM_SLOTS-1:0] wr_oh_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             full;

  assign full = (cnt_q == CNT_W'(NUM_SLOTS));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_sel
    assign wr_oh_o[i] = push_i && !clr_i && (cnt_q == CNT_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (push_i && !full)    cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(NUM_SLOTS));
  assert_single_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_oh_o));
  assert_full_no_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> (wr_oh_o == '0));
  assert_clr_cnt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/sld_slot.sv
module sld_slot
  import sld_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     wr_i,
  input  mem_acc_t st_i,
  input  mem_acc_t ld_i,
  output logic     hit_o
);
  logic     vld_q;
  mem_acc_t ent_q;

  logic                    same_base;
  logic                    exact;
  logic signed [OFF_W-1:0] st_end;
  logic signed [OFF_W-1:0] ld_end;
  logic                    range_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ent_q <= '0;
    end else if (clr_i) begin
      vld_q <= 1'b0;
    end else if (wr_i) begin
      vld_q <= 1'b1;
      ent_q <= st_i;
    end
  end

  always_comb begin
    same_base = (ent_q.base == ld_i.base);
    exact     = same_base && (ent_q.off == ld_i.off);
    st_end    = ent_q.off + signed'(ent_q.size);
    ld_end    = ld_i.off + signed'(ld_i.size);
    if (ent_q.off < ld_i.off) range_hit = (st_end > ld_i.off);
    else                      range_hit = (ld_end > ent_q.off);
    hit_o = vld_q && (exact || (same_base && range_hit));
  end

  assert_slot_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> (vld_q && ent_q == $past(st_i)));
  assert_slot_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !vld_q);
  assert_slot_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !clr_i) |=> ($stable(vld_q) && $stable(ent_q)));
endmodule

// File: rtl/store_load_overlap.sv
module store_load_overlap
  import sld_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    group_end_i,
  input  logic                    commit_i,
  input  logic                    commit_is_store_i,
  input  logic                    commit_opnd_vld_i,
  input  logic [BASE_W-1:0]       st_base_i,
  input  logic signed [OFF_W-1:0] st_off_i,
  input  logic [OFF_W-1:0]        st_size_i,
  input  logic                    chk_is_load_i,
  input  logic                    chk_opnd_vld_i,
  input  logic [BASE_W-1:0]       ld_base_i,
  input  logic signed [OFF_W-1:0] ld_off_i,
  input  logic [OFF_W-1:0]        ld_size_i,
  output logic                    overlap_o
);
  mem_acc_t             st_acc;
  mem_acc_t             ld_acc;
  logic                 push;
  logic [NUM_SLOTS-1:0] wr_oh;
  logic [NUM_SLOTS-1:0] hits;

  assign st_acc = '{base: st_base_i, off: st_off_i, size: st_size_i};
  assign ld_acc = '{base: ld_base_i, off: ld_off_i, size: ld_size_i};
  assign push   = commit_i && commit_is_store_i && commit_opnd_vld_i;

  sld_fill_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_fill (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (group_end_i),
    .push_i (push),
    .wr_oh_o(wr_oh)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    sld_slot u_slot (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (group_end_i),
      .wr_i  (wr_oh[i]),
      .st_i  (st_acc),
      .ld_i  (ld_acc),
      .hit_o (hits[i])
    );
  end

  assign overlap_o = chk_is_load_i && chk_opnd_vld_i && (|hits);

  assert_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overlap_o |-> (chk_is_load_i && chk_opnd_vld_i));
  assert_empty_after_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    group_end_i |=> !overlap_o);
  assert_no_write_without_push_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push |-> (wr_oh == '0));
endmodule

// File: tb/store_load_overlap_bench.sv
module store_load_overlap_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic group_end = 1'b0, commit = 1'b0, is_store = 1'b0, opnd_vld = 1'b0;
  logic [15:0] st_base = '0, ld_base = '0;
  logic signed [63:0] st_off = '0, ld_off = '0;
  logic [63:0] st_size = '0, ld_size = '0;
  logic is_load = 1'b0, ld_vld = 1'b0;
  logic overlap;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  store_load_overlap u_store_load_overlap (
    .clk_i(clk), .rst_ni(rst_n), .group_end_i(group_end), .commit_i(commit),
    .commit_is_store_i(is_store), .commit_opnd_vld_i(opnd_vld),
    .st_base_i(st_base), .st_off_i(st_off), .st_size_i(st_size),
    .chk_is_load_i(is_load), .chk_opnd_vld_i(ld_vld),
    .ld_base_i(ld_base), .ld_off_i(ld_off), .ld_size_i(ld_size),
    .overlap_o(overlap)
  );

  task automatic commit_op(input logic [15:0] b, input logic signed [63:0] o,
                           input logic [63:0] s, input logic c, input logic st,
                           input logic v, input logic ge);
    @(negedge clk);
    commit = c; is_store = st; opnd_vld = v; group_end = ge;
    st_base = b; st_off = o; st_size = s;
    @(negedge clk);
    commit = 0; is_store = 0; opnd_vld = 0; group_end = 0;
  endtask

  task automatic store(input logic [15:0] b, input logic signed [63:0] o, input logic [63:0] s);
    commit_op(b, o, s, 1, 1, 1, 0);
  endtask

  task automatic end_group();
    commit_op(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic probe_full(input logic [15:0] b, input logic signed [63:0] o,
                            input logic [63:0] s, input logic ld, input logic v,
                            input logic exp, input string tag);
    @(negedge clk);
    ld_base = b; ld_off = o; ld_size = s; is_load = ld; ld_vld = v;
    #5;
    checks++;
    if (overlap !== exp) begin
      errors++;
      $display("FAIL %s: base=%0d off=%0d size=%0d overlap=%b expected=%b",
               tag, b, o, s, overlap, exp);
    end
    is_load = 0; ld_vld = 0;
  endtask

  task automatic probe(input logic [15:0] b, input logic signed [63:0] o,
                       input logic [63:0] s, input logic exp, input string tag);
    probe_full(b, o, s, 1, 1, exp, tag);
  endtask

  task automatic t_reset();
    probe(1, 0, 8, 0, "R9 empty after reset");
    probe(0, 0, 0, 0, "R9 zero access after reset");
  endtask

  task automatic t_exact();
    end_group();
    store(1, 16, 0);
    probe(1, 16, 0, 1, "R2 exact match zero sizes");
    probe(1, 15, 1, 0, "R4 adjacent below zero-size store");
    probe_full(1, 16, 0, 0, 1, 0, "R6 not a load");
    probe_full(1, 16, 0, 1, 0, 0, "R6 no operand info");
  endtask

  task automatic t_ranges();
    end_group();
    store(2, 0, 8);
    probe(2, 7, 1, 1, "R3 last byte of store");
    probe(2, 8, 4, 0, "R3 just past store");
    probe(2, -4, 4, 0, "R4 load ends at store start");
    probe(2, -4, 5, 1, "R4 load reaches store start");
    probe(3, 0, 8, 0, "R5 different base");
  endtask

  task automatic t_record_gate();
    end_group();
    commit_op(4, 0, 8, 1, 0, 1, 0);
    probe(4, 0, 8, 0, "R7 non-store commit ignored");
    commit_op(4, 0, 8, 1, 1, 0, 0);
    probe(4, 0, 8, 0, "R7 store without operand info ignored");
    commit_op(4, 0, 8, 0, 1, 1, 0);
    probe(4, 0, 8, 0, "R7 no commit strobe ignored");
  endtask

  task automatic t_capacity();
    end_group();
    for (int i = 0; i < 5; i++) store(5, 64'(i * 100), 4);
    probe(5, 0, 4, 1, "R1 first entry kept");
    probe(5, 300, 4, 1, "R1 fourth entry kept");
    probe(5, 400, 4, 0, "R1 fifth store dropped");
  endtask

  task automatic t_clear();
    end_group();
    probe(5, 0, 4, 0, "R8 clear empties table");
    commit_op(6, 0, 8, 1, 1, 1, 1);
    probe(6, 0, 8, 0, "R8 commit with group end dropped");
    store(6, 0, 8);
    probe(6, 0, 8, 1, "R8 recording after clear");
  endtask

  task automatic t_signed();
    end_group();
    store(7, -100, 50);
    probe(7, -60, 1, 1, "R10 negative offsets inside");
    probe(7, -50, 1, 0, "R10 negative offsets past end");
    probe(7, -101, 1, 0, "R10 ends right before store");
    probe(7, -101, 2, 1, "R10 covers store start");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_exact();
    t_ranges();
    t_record_gate();
    t_capacity();
    t_clear();
    t_signed();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule